// File: doc/BRIEF.md
# Range-Gated Segmented Adder/Subtractor

This block adds or subtracts two 32-bit two's complement words while doing only as much work as the operands need. For each operation it measures how many low-order bits of each operand carry information. Every bit above that count is a copy of the sign. The larger of the two measurements, plus one guard bit, sets how many 8-bit adder segments take part.

Only those low segments load new operand bits into their input register. The upper segments keep their previous contents, so their adder logic does not toggle. The narrow sum from the active segments is then widened back to 32 bits by copying its top bit upward.

Operands are captured in an input register stage, and the result is captured in an output register stage. A request presented with `in_valid` therefore appears on the outputs two clock edges later. The outputs carry the 32-bit result, a flag and the number of segments that were used.

Top module: `rng_gated_adder`

## Requirements
- R1: While `rst` is high and after it falls, until the first result, `out_valid` is 0, `out_result` is 0 and `out_segs` is 0.
- R2: With `in_sub` = 0, `out_result` equals `in_a + in_b` modulo 2^32.
- R3: With `in_sub` = 1, `out_result` equals `in_a - in_b` modulo 2^32, formed as `in_a + ~in_b + 1`.
- R4: The effective range of a value is the smallest n in 1..32 such that the value fits in an n-bit signed field. `out_segs` equals ceil((max(range(in_a), range(b')) + 1) / 8), clamped to 1..4. Here b' is `in_b` for addition and `~in_b` for subtraction.
- R5: On an accepted request, an input-register segment k (bits 8k+7..8k) of both operands loads only if k < the selected segment count; otherwise it keeps its prior value.
- R6: When `out_segs` < 4, every result bit at position 8*`out_segs` or above equals bit 8*`out_segs`-1 of the result.
- R7: When four segments are used, the result is the plain 32-bit wrap-around value; for example 0x7FFFFFFF + 1 gives 0x80000000.
- R8: `out_valid` is 1 exactly on the cycle two clock edges after `in_valid` was sampled high, and 0 otherwise. `out_result` and `out_segs` hold their values when no request completes.
- R9: Stale operand bits left in frozen upper segments never change the result of a later narrow operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe; operands sampled on this edge |
| in_a | input | 32 | First operand, two's complement |
| in_b | input | 32 | Second operand, two's complement |
| in_sub | input | 1 | 0 = add, 1 = subtract (a - b) |
| out_valid | output | 1 | Result valid, one cycle per request |
| out_result | output | 32 | Registered sum or difference |
| out_segs | output | 3 | Number of 8-bit segments used, 1..4 |

## Verification
A request driven before edge N is captured by the input stage at edge N. Its result, segment count and flag become visible after edge N+1. The bench therefore drives on a falling edge and drops `in_valid` on the next falling edge. At that point it confirms the flag is still low, then samples all three outputs on the falling edge after that. Expected segment counts come from an arithmetic range-fit test in the bench, and expected results come from native 32-bit arithmetic. Idle cycles are checked to show the outputs stay put.

// File: rtl/rga_pkg.sv
package rga_pkg;

  localparam int DEF_DATA_W = 32;
  localparam int DEF_SEG_W  = 8;

  // Number of segments needed to hold 'need' bits, limited to 1..nseg.
  function automatic int seg_count(int need, int seg_w, int nseg);
    int c;
    c = (need + seg_w - 1) / seg_w;
    if (c < 1)    c = 1;
    if (c > nseg) c = nseg;
    return c;
  endfunction

endpackage

// File: rtl/rga_range_detect.sv
// Smallest signed field width (1..DATA_W) that holds the value.
module rga_range_detect #(
  parameter int DATA_W = 32,
  parameter int RNG_W  = 6
) (
  input  logic [DATA_W-1:0] val,
  output logic [RNG_W-1:0]  rng
);

  // Bits that differ from the sign bit mark information content.
  logic [DATA_W-2:0] diff;

  assign diff = val[DATA_W-2:0] ^ {(DATA_W-1){val[DATA_W-1]}};

  always_comb begin
    rng = RNG_W'(1);
    for (int i = 0; i < DATA_W - 1; i++) begin
      if (diff[i]) rng = RNG_W'(i + 2);
    end
  end

endmodule

// File: rtl/rga_seg_select.sv
// Picks the segment count from the wider operand range plus a guard bit.
module rga_seg_select
  import rga_pkg::*;
#(
  parameter int SEG_W = 8,
  parameter int NSEG  = 4,
  parameter int RNG_W = 6,
  parameter int CNT_W = 3
) (
  input  logic [RNG_W-1:0] rng_a,
  input  logic [RNG_W-1:0] rng_b,
  output logic [CNT_W-1:0] cnt,
  output logic [NSEG-1:0]  en
);

  logic [RNG_W-1:0] wide;

  assign wide = (rng_a > rng_b) ? rng_a : rng_b;

  always_comb begin
    cnt = CNT_W'(seg_count(int'(wide) + 1, SEG_W, NSEG));
  end

  // Thermometer enable: segment k active when k < cnt.
  for (genvar k = 0; k < NSEG; k++) begin : g_en
    assign en[k] = (cnt > CNT_W'(k));
  end

endmodule

// File: rtl/rga_master_stage.sv
// Input register stage; each operand segment loads only when enabled.
module rga_master_stage #(
  parameter int DATA_W = 32,
  parameter int SEG_W  = 8,
  parameter int NSEG   = 4,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b_eff,
  input  logic              in_cin,
  input  logic [CNT_W-1:0]  in_cnt,
  input  logic [NSEG-1:0]   in_en,
  output logic [NSEG-1:0]   seg_ld,
  output logic [DATA_W-1:0] ma,
  output logic [DATA_W-1:0] mb,
  output logic              mcin,
  output logic [CNT_W-1:0]  mcnt,
  output logic              mvalid
);

  assign seg_ld = {NSEG{in_valid}} & in_en;

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst) begin
        ma[k*SEG_W +: SEG_W] <= '0;
        mb[k*SEG_W +: SEG_W] <= '0;
      end else if (seg_ld[k]) begin
        ma[k*SEG_W +: SEG_W] <= in_a[k*SEG_W +: SEG_W];
        mb[k*SEG_W +: SEG_W] <= in_b_eff[k*SEG_W +: SEG_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mvalid <= 1'b0;
      mcin   <= 1'b0;
      mcnt   <= '0;
    end else begin
      mvalid <= in_valid;
      if (in_valid) begin
        mcin <= in_cin;
        mcnt <= in_cnt;
      end
    end
  end

endmodule

// File: rtl/rga_seg_adder.sv
// Segmented ripple adder with carry gating and sign-extension fill.
module rga_seg_adder #(
  parameter int DATA_W = 32,
  parameter int SEG_W  = 8,
  parameter int NSEG   = 4,
  parameter int CNT_W  = 3
) (
  input  logic [DATA_W-1:0] ma,
  input  logic [DATA_W-1:0] mb,
  input  logic              cin,
  input  logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] sum
);

  logic [NSEG:0]     carry;
  logic [NSEG-1:0]   act;
  logic [DATA_W-1:0] raw;
  logic              top_bit;
  logic              unused_carry_out;

  assign carry[0]         = cin;
  assign unused_carry_out = carry[NSEG];

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    logic [SEG_W:0] part;
    logic           cin_k;

    assign act[k] = (cnt > CNT_W'(k));
    // An inactive segment sees no carry, so its frozen inputs stay quiet.
    assign cin_k  = act[k] ? carry[k] : 1'b0;
    assign part   = {1'b0, ma[k*SEG_W +: SEG_W]}
                  + {1'b0, mb[k*SEG_W +: SEG_W]}
                  + {{SEG_W{1'b0}}, cin_k};
    assign raw[k*SEG_W +: SEG_W] = part[SEG_W-1:0];
    assign carry[k+1]            = part[SEG_W];
  end

  // Most significant bit of the active portion.
  always_comb begin
    top_bit = raw[SEG_W-1];
    for (int k = 0; k < NSEG; k++) begin
      if (cnt == CNT_W'(k + 1)) top_bit = raw[k*SEG_W + SEG_W - 1];
    end
  end

  for (genvar k = 0; k < NSEG; k++) begin : g_fill
    assign sum[k*SEG_W +: SEG_W] = act[k] ? raw[k*SEG_W +: SEG_W]
                                          : {SEG_W{top_bit}};
  end

endmodule

// File: rtl/rng_gated_adder.sv
module rng_gated_adder
  import rga_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int SEG_W  = DEF_SEG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic              in_sub,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic [2:0]        out_segs
);

  localparam int NSEG  = DATA_W / SEG_W;
  localparam int CNT_W = $clog2(NSEG + 1);
  localparam int RNG_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] b_eff;
  logic [RNG_W-1:0]  rng_a;
  logic [RNG_W-1:0]  rng_b;
  logic [CNT_W-1:0]  sel_cnt;
  logic [NSEG-1:0]   sel_en;
  logic [NSEG-1:0]   seg_ld;
  logic [DATA_W-1:0] ma_q;
  logic [DATA_W-1:0] mb_q;
  logic              mcin_q;
  logic [CNT_W-1:0]  mcnt_q;
  logic              mvalid_q;
  logic [DATA_W-1:0] sum_w;

  assign b_eff = in_sub ? ~in_b : in_b;

  rga_range_detect #(.DATA_W(DATA_W), .RNG_W(RNG_W)) u_rng_a (
    .val (in_a),
    .rng (rng_a)
  );

  rga_range_detect #(.DATA_W(DATA_W), .RNG_W(RNG_W)) u_rng_b (
    .val (b_eff),
    .rng (rng_b)
  );

  rga_seg_select #(
    .SEG_W (SEG_W), .NSEG (NSEG), .RNG_W (RNG_W), .CNT_W (CNT_W)
  ) u_sel (
    .rng_a (rng_a),
    .rng_b (rng_b),
    .cnt   (sel_cnt),
    .en    (sel_en)
  );

  rga_master_stage #(
    .DATA_W (DATA_W), .SEG_W (SEG_W), .NSEG (NSEG), .CNT_W (CNT_W)
  ) u_master (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_a     (in_a),
    .in_b_eff (b_eff),
    .in_cin   (in_sub),
    .in_cnt   (sel_cnt),
    .in_en    (sel_en),
    .seg_ld   (seg_ld),
    .ma       (ma_q),
    .mb       (mb_q),
    .mcin     (mcin_q),
    .mcnt     (mcnt_q),
    .mvalid   (mvalid_q)
  );

  rga_seg_adder #(
    .DATA_W (DATA_W), .SEG_W (SEG_W), .NSEG (NSEG), .CNT_W (CNT_W)
  ) u_add (
    .ma  (ma_q),
    .mb  (mb_q),
    .cin (mcin_q),
    .cnt (mcnt_q),
    .sum (sum_w)
  );

  // Output (slave) register stage.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_segs   <= '0;
    end else begin
      out_valid <= mvalid_q;
      if (mvalid_q) begin
        out_result <= sum_w;
        out_segs   <= 3'(mcnt_q);
      end
    end
  end

endmodule

// File: rtl/rga_checker.sv
module rga_checker #(
  parameter int DATA_W = 32,
  parameter int SEG_W  = 8,
  parameter int NSEG   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [NSEG-1:0]   seg_ld,
  input logic [DATA_W-1:0] ma,
  input logic [DATA_W-1:0] mb,
  input logic              mvalid,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_result,
  input logic [2:0]        out_segs
);

  logic osign;

  always_comb begin
    osign = 1'b0;
    for (int k = 0; k < NSEG; k++) begin
      if (out_segs == 3'(k + 1)) osign = out_result[k*SEG_W + SEG_W - 1];
    end
  end

  // R5: a segment that did not load keeps its operand bits.
  for (genvar k = 0; k < NSEG; k++) begin : g_frz
    a_r5_freeze: assert property (@(posedge clk) disable iff (rst)
      !seg_ld[k] |=> ($stable(ma[k*SEG_W +: SEG_W]) && $stable(mb[k*SEG_W +: SEG_W])));

    // R6: unused upper segments are filled with the active top bit.
    a_r6_fill: assert property (@(posedge clk) disable iff (rst)
      (out_valid && (out_segs <= 3'(k))) |-> (out_result[k*SEG_W +: SEG_W] == {SEG_W{osign}}));
  end

  // R5: load enables form a thermometer code from segment 0 upward.
  a_r5_thermo: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (seg_ld[0] && $onehot0(seg_ld ^ (seg_ld >> 1))));

  // R4: reported count is within 1..NSEG.
  a_r4_cnt_bounds: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_segs >= 3'd1 && out_segs <= 3'(NSEG)));

  // R8: request flows through both stages one edge each.
  a_r8_stage1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> mvalid);
  a_r8_stage2: assert property (@(posedge clk) disable iff (rst)
    mvalid |=> out_valid);
  a_r8_idle: assert property (@(posedge clk) disable iff (rst)
    !mvalid |=> (!out_valid && $stable(out_result) && $stable(out_segs)));

endmodule

bind rng_gated_adder rga_checker #(
  .DATA_W (DATA_W), .SEG_W (SEG_W), .NSEG (NSEG)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .seg_ld     (seg_ld),
  .ma         (ma_q),
  .mb         (mb_q),
  .mvalid     (mvalid_q),
  .out_valid  (out_valid),
  .out_result (out_result),
  .out_segs   (out_segs)
);

// File: tb/rng_gated_adder_tb.sv
module rng_gated_adder_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] in_a;
  logic [31:0] in_b;
  logic        in_sub;
  logic        out_valid;
  logic [31:0] out_result;
  logic [2:0]  out_segs;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rng_gated_adder u_dut (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_a       (in_a),
    .in_b       (in_b),
    .in_sub     (in_sub),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_segs   (out_segs)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  // Smallest signed field width holding v (arithmetic, not bitwise).
  function automatic int fit_width(logic [31:0] v);
    longint s = longint'($signed(v));
    for (int n = 1; n <= 32; n++) begin
      longint lim = longint'(1) << (n - 1);
      if (s >= -lim && s <= lim - 1) return n;
    end
    return 32;
  endfunction

  function automatic int want_segs(logic [31:0] a, logic [31:0] b, logic sub);
    int ra = fit_width(a);
    int rb = fit_width(sub ? ~b : b);
    int need = ((ra > rb) ? ra : rb) + 1;
    int c = (need + 7) / 8;
    if (c > 4) c = 4;
    return c;
  endfunction

  // One request; results due two edges later (R2, R3, R4, R8).
  task automatic run_op(logic [31:0] a, logic [31:0] b, logic sub, string req);
    logic [31:0] exp_r = sub ? (a - b) : (a + b);
    @(negedge clk);
    in_a = a; in_b = b; in_sub = sub; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({"R8 early ", req}, {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    chk({"R8 valid ", req}, {31'd0, out_valid}, 32'd1);
    chk({req, " result"}, out_result, exp_r);
    chk({"R4 segs ", req}, {29'd0, out_segs}, 32'(want_segs(a, b, sub)));
  endtask

  task automatic t_reset;
    rst = 1'b1; in_valid = 1'b1; in_a = 32'h1234_5678; in_b = 32'h1; in_sub = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {31'd0, out_valid}, 32'd0);
    chk("R1 result in reset", out_result, 32'd0);
    chk("R1 segs in reset", {29'd0, out_segs}, 32'd0);
    in_valid = 1'b0;
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 valid after reset", {31'd0, out_valid}, 32'd0);
    chk("R1 result after reset", out_result, 32'd0);
  endtask

  task automatic t_add;
    run_op(32'd5, 32'd9, 1'b0, "R2");
    run_op(32'd100, 32'd27, 1'b0, "R2");
    run_op(32'hFFFF_FF00, 32'd55, 1'b0, "R2");
    run_op(32'h0001_2345, 32'h0000_1111, 1'b0, "R2");
    run_op(32'h4000_0000, 32'h3FFF_FFFF, 1'b0, "R2");
  endtask

  task automatic t_sub;
    run_op(32'd3, 32'd10, 1'b1, "R3 R6");     // -7, one segment
    run_op(32'd1000, 32'd1, 1'b1, "R3");
    run_op(32'hFFFF_FF80, 32'd50, 1'b1, "R3");
    run_op(32'h0012_0000, 32'hFFFF_0000, 1'b1, "R3");
    run_op(32'd0, 32'h8000_0000, 1'b1, "R3 R7");
  endtask

  task automatic t_boundary;
    logic [31:0] vals [6] = '{32'd0, 32'hFFFF_FFFF, 32'd127, 32'hFFFF_FF80,
                              32'h8000_0000, 32'h7FFF_FFFF};
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        run_op(vals[i], vals[j], 1'b0, "R2 R6 R7 boundary");
        run_op(vals[i], vals[j], 1'b1, "R3 R6 R7 boundary");
      end
    end
    // R7: wrap at the top of the range.
    run_op(32'h7FFF_FFFF, 32'd1, 1'b0, "R7 wrap");
    chk("R7 segs", {29'd0, out_segs}, 32'd4);
  endtask

  // R5 / R9: wide load leaves upper bits behind, narrow ops must ignore them.
  task automatic t_freeze;
    run_op(32'h7A5C_3E11, 32'h5234_5678, 1'b0, "R9 wide");
    run_op(32'd5, 32'hFFFF_FFFD, 1'b0, "R5 R9 narrow add");
    chk("R5 narrow count", {29'd0, out_segs}, 32'd1);
    run_op(32'h6B00_0000, 32'h1C00_0000, 1'b1, "R9 wide");
    run_op(32'hFFFF_FF9C, 32'd27, 1'b1, "R5 R9 R6 narrow sub");
    run_op(32'd200, 32'd100, 1'b0, "R5 R9 two segments");
    chk("R5 two-segment count", {29'd0, out_segs}, 32'd2);
  endtask

  task automatic t_random;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a = $urandom;
      logic [31:0] b = $urandom;
      logic        s = 1'($urandom);
      if (i % 3 == 1) begin
        a = 32'($signed(a[9:0]));
        b = 32'($signed(b[11:0]));
      end else if (i % 3 == 2) begin
        a = 32'($signed(a[18:0]));
        b = 32'($signed(b[5:0]));
      end
      run_op(a, b, s, s ? "R3 random" : "R2 random");
    end
  endtask

  // R8: outputs hold and valid stays low with no requests.
  task automatic t_hold;
    logic [31:0] r;
    logic [2:0]  sg;
    run_op(32'hFFFF_FFF0, 32'd3, 1'b0, "R2 before idle");
    r  = out_result;
    sg = out_segs;
    in_a = 32'h7777_7777; in_b = 32'h1234_0000;
    repeat (4) begin
      @(negedge clk);
      chk("R8 idle valid", {31'd0, out_valid}, 32'd0);
      chk("R8 idle result", out_result, r);
      chk("R8 idle segs", {29'd0, out_segs}, {29'd0, sg});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_boundary();
    t_freeze();
    t_random();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule